// File: doc/BRIEF.md
# Receive event queue controller

This unit accepts receive events over a valid/ready request interface and files each one into one of two 16-entry queues: a normal event queue and an error queue. Every event carries a two-bit kind (good frame, bad frame, error, counter overflow) and a 16-bit payload. The kind and a handful of mode bits decide whether an event is queued as normal, sent to the error queue, or discarded.

A 32-bit mode register is changed through a set strobe and a clear strobe that share one write-data bus. The mode register can hold off all new requests, turn on timestamp entries, and pick the error routing policy. In timestamp mode, a timestamp entry holding the cycle count at acceptance goes in just ahead of each queued event, and the two entries are written in the same cycle. A diagnostic-only strobe bit empties both queues at once. A timestamp register holds the cycle count at which the normal queue was last popped. Consumers read the head of each queue directly and pop it with a strobe.

Top module: `rxevq_top`

## Requirements
- R1: After reset the mode register reads 0x00000300, both queues are empty and not full, and the timestamp register reads 0.
- R2: A set strobe turns on every mode bit whose write-data bit is 1, and a clear strobe turns off every such bit. Only bits 10..0 can be written. Bits 31..11 always read 0. When set and clear are strobed in the same cycle, clear takes effect after set, so the clear wins.
- R3: Writing write-data bit 31 through the set strobe while diag_mode is high empties both queues at the next edge, and requests and pops are refused in that cycle. Without diag_mode the bit has no effect. Bit 31 always reads 0.
- R4: Kind codes are 0 good, 1 bad frame, 2 error and 3 counter overflow. A good event goes to the normal queue. A bad-frame event goes to the normal queue when mode bit 2 is 1 and is otherwise dropped. A counter-overflow event goes to the normal queue when mode bit 6 is 1 and is otherwise dropped. A dropped event still completes its handshake.
- R5: An error event goes to the error queue when mode bit 7 is 1 or mode bit 2 is 0. Otherwise it goes to the normal queue, in order with the other events there.
- R6: When mode bit 3 is 1, each queued event is preceded in the same queue by a timestamp entry. That entry has its is_ts flag at 1, the same kind as the event, and data equal to the cycle counter at acceptance. Both entries are written in one cycle. Real entries have is_ts at 0 and carry evt_data.
- R7: While mode bit 4 is 1, evt_ready is 0 for every kind.
- R8: evt_ready is 0 when the target queue has fewer free entries than needed (two in timestamp mode, otherwise one). An event that is dropped, or that targets the other queue, is still accepted.
- R9: Each queue holds 16 entries and is first in, first out. The full flag is set at 16 entries and the empty flag at 0. A pop on an empty queue is ignored.
- R10: The cycle counter reads 0 in the first cycle after reset and advances by one each cycle. When the normal queue is popped while it is not empty, the timestamp register captures the counter value of that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| diag_mode | input | 1 | Enables the flush bit |
| reg_wr_set | input | 1 | Set strobe for the mode register |
| reg_wr_clr | input | 1 | Clear strobe for the mode register |
| reg_wdata | input | 32 | Bit mask for set/clear |
| ctrl_rdata | output | 32 | Mode register value |
| ts_rdata | output | 16 | Timestamp register (time of last normal pop) |
| evt_valid | input | 1 | Event request valid |
| evt_kind | input | 2 | Event kind code |
| evt_data | input | 16 | Event payload |
| evt_ready | output | 1 | Event accepted when high with evt_valid |
| nq_pop | input | 1 | Pop normal queue head |
| nq_is_ts | output | 1 | Normal head is a timestamp entry |
| nq_kind | output | 2 | Normal head kind |
| nq_data | output | 16 | Normal head data |
| nq_empty | output | 1 | Normal queue empty |
| nq_full | output | 1 | Normal queue full |
| eq_pop | input | 1 | Pop error queue head |
| eq_is_ts | output | 1 | Error head is a timestamp entry |
| eq_kind | output | 2 | Error head kind |
| eq_data | output | 16 | Error head data |
| eq_empty | output | 1 | Error queue empty |
| eq_full | output | 1 | Error queue full |

## Verification
The bench fills the normal queue with timestamp pairs and then checks the room test at 15 entries in both modes. A design that checked for one free slot instead of two would write past full or split a pair. It drives every kind under each combination of bits 2 and 7, where swapped priority sends error events to the wrong queue. It also strobes the flush bit with and without diag_mode and strobes set and clear together, because a wrong gate or a wrong ordering changes queue contents or register readback. Random traffic with concurrent pops compares every head and the timestamp register against a bench model, which catches misaligned pop/push accounting and off-by-one capture times.

// File: rtl/rxevq_pkg.sv
package rxevq_pkg;

    localparam int DATA_W = 16;
    localparam int CTRL_W = 32;

    localparam int B_RXBAD   = 2;
    localparam int B_TSMODE  = 3;
    localparam int B_INHIBIT = 4;
    localparam int B_OVF_EN  = 6;
    localparam int B_ALLERR  = 7;
    localparam int B_FLUSH   = 31;

    localparam logic [CTRL_W-1:0] CTRL_RESET = 32'h0000_0300;
    localparam logic [CTRL_W-1:0] CTRL_WMASK = 32'h0000_07FF;

    typedef enum logic [1:0] {
        EV_GOOD = 2'd0,
        EV_BAD  = 2'd1,
        EV_ERR  = 2'd2,
        EV_OVF  = 2'd3
    } ev_kind_e;

    typedef enum logic [1:0] {
        TGT_DROP = 2'd0,
        TGT_NORM = 2'd1,
        TGT_ERRQ = 2'd2
    } tgt_e;

    typedef struct packed {
        logic              is_ts;
        ev_kind_e          kind;
        logic [DATA_W-1:0] data;
    } q_entry_t;

    function automatic tgt_e route_event(ev_kind_e k, logic rx_bad,
                                         logic ovf_en, logic all_err);
        tgt_e t;
        unique case (k)
            EV_GOOD: t = TGT_NORM;
            EV_BAD:  t = rx_bad ? TGT_NORM : TGT_DROP;
            EV_ERR:  t = (all_err || !rx_bad) ? TGT_ERRQ : TGT_NORM;
            default: t = ovf_en ? TGT_NORM : TGT_DROP;
        endcase
        return t;
    endfunction

endpackage

// File: rtl/rxevq_ctrl_reg.sv
module rxevq_ctrl_reg
    import rxevq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              diag_mode,
    input  logic              wr_set,
    input  logic              wr_clr,
    input  logic [CTRL_W-1:0] wdata,
    output logic [CTRL_W-1:0] ctrl_q,
    output logic              flush_pulse
);

    logic [CTRL_W-1:0] ctrl_d;
    logic [CTRL_W-1:0] wmask;

    assign wmask       = wdata & CTRL_WMASK;
    assign flush_pulse = wr_set && wdata[B_FLUSH] && diag_mode;

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_set) ctrl_d = ctrl_d | wmask;
        if (wr_clr) ctrl_d = ctrl_d & ~wmask;
    end

    always_ff @(posedge clk) begin
        if (rst) ctrl_q <= CTRL_RESET;
        else     ctrl_q <= ctrl_d;
    end

endmodule

// File: rtl/rxevq_fifo.sv
module rxevq_fifo
    import rxevq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     flush,
    input  logic     push0,
    input  logic     push1,
    input  q_entry_t din0,
    input  q_entry_t din1,
    input  logic     pop,
    output q_entry_t head,
    output logic     empty,
    output logic     full,
    output logic [CW-1:0] count
);

    q_entry_t        mem [DEPTH];
    logic [AW-1:0]   wr_ptr, rd_ptr;
    logic            pop_ok;
    logic [1:0]      n_push;

    assign empty  = (count == '0);
    assign full   = (count == CW'(DEPTH));
    assign head   = mem[rd_ptr];
    assign pop_ok = pop && !empty && !flush;
    assign n_push = {1'b0, push0} + {1'b0, push0 && push1};

    always_ff @(posedge clk) begin
        if (push0 && !flush) mem[wr_ptr] <= din0;
        if (push0 && push1 && !flush) mem[wr_ptr + AW'(1)] <= din1;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            wr_ptr <= wr_ptr + AW'(n_push);
            rd_ptr <= rd_ptr + AW'(pop_ok);
            count  <= count + CW'(n_push) - CW'(pop_ok);
        end
    end

endmodule

// File: rtl/rxevq_top.sv
module rxevq_top
    import rxevq_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        diag_mode,
    input  logic        reg_wr_set,
    input  logic        reg_wr_clr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] ctrl_rdata,
    output logic [15:0] ts_rdata,
    input  logic        evt_valid,
    input  logic [1:0]  evt_kind,
    input  logic [15:0] evt_data,
    output logic        evt_ready,
    input  logic        nq_pop,
    output logic        nq_is_ts,
    output logic [1:0]  nq_kind,
    output logic [15:0] nq_data,
    output logic        nq_empty,
    output logic        nq_full,
    input  logic        eq_pop,
    output logic        eq_is_ts,
    output logic [1:0]  eq_kind,
    output logic [15:0] eq_data,
    output logic        eq_empty,
    output logic        eq_full
);

    localparam int NQ = 2;
    localparam int CW = $clog2(DEPTH) + 1;
    localparam logic [CW:0] DEPTH_C = (CW+1)'(DEPTH);

    logic [CTRL_W-1:0] ctrl_q;
    logic              flush_pulse;
    logic [DATA_W-1:0] time_cnt, ts_q;

    tgt_e              tgt;
    logic              ts_mode, accept, tgt_err, room;
    logic [CW-1:0]     sel_cnt;
    logic [CW:0]       need;
    q_entry_t          ev_ent, ts_ent, din0;

    logic [NQ-1:0]     push0, push1, pops, q_empty, q_full;
    q_entry_t          q_head [NQ];
    logic [CW-1:0]     q_cnt  [NQ];

    rxevq_ctrl_reg u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .diag_mode  (diag_mode),
        .wr_set     (reg_wr_set),
        .wr_clr     (reg_wr_clr),
        .wdata      (reg_wdata),
        .ctrl_q     (ctrl_q),
        .flush_pulse(flush_pulse)
    );

    assign ts_mode = ctrl_q[B_TSMODE];
    assign tgt     = route_event(ev_kind_e'(evt_kind), ctrl_q[B_RXBAD],
                                 ctrl_q[B_OVF_EN], ctrl_q[B_ALLERR]);
    assign tgt_err = (tgt == TGT_ERRQ);
    assign sel_cnt = tgt_err ? q_cnt[1] : q_cnt[0];
    assign need    = ts_mode ? (CW+1)'(2) : (CW+1)'(1);
    assign room    = ({1'b0, sel_cnt} + need) <= DEPTH_C;

    assign evt_ready = !flush_pulse && !ctrl_q[B_INHIBIT] &&
                       ((tgt == TGT_DROP) || room);
    assign accept    = evt_valid && evt_ready;

    always_comb begin
        ev_ent.is_ts = 1'b0;
        ev_ent.kind  = ev_kind_e'(evt_kind);
        ev_ent.data  = evt_data;
        ts_ent.is_ts = 1'b1;
        ts_ent.kind  = ev_kind_e'(evt_kind);
        ts_ent.data  = time_cnt;
        din0         = ts_mode ? ts_ent : ev_ent;
    end

    assign pops = {eq_pop, nq_pop};

    for (genvar gi = 0; gi < NQ; gi++) begin : g_q
        assign push0[gi] = accept && (tgt != TGT_DROP) && (tgt_err == (gi == 1));
        assign push1[gi] = push0[gi] && ts_mode;

        rxevq_fifo #(.DEPTH(DEPTH)) u_fifo (
            .clk  (clk),
            .rst  (rst),
            .flush(flush_pulse),
            .push0(push0[gi]),
            .push1(push1[gi]),
            .din0 (din0),
            .din1 (ev_ent),
            .pop  (pops[gi]),
            .head (q_head[gi]),
            .empty(q_empty[gi]),
            .full (q_full[gi]),
            .count(q_cnt[gi])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            time_cnt <= '0;
            ts_q     <= '0;
        end else begin
            time_cnt <= time_cnt + 1'b1;
            if (nq_pop && !q_empty[0] && !flush_pulse) ts_q <= time_cnt;
        end
    end

    assign ctrl_rdata = ctrl_q;
    assign ts_rdata   = ts_q;

    assign nq_is_ts = q_head[0].is_ts;
    assign nq_kind  = q_head[0].kind;
    assign nq_data  = q_head[0].data;
    assign nq_empty = q_empty[0];
    assign nq_full  = q_full[0];
    assign eq_is_ts = q_head[1].is_ts;
    assign eq_kind  = q_head[1].kind;
    assign eq_data  = q_head[1].data;
    assign eq_empty = q_empty[1];
    assign eq_full  = q_full[1];

endmodule

// File: rtl/rxevq_checker.sv
module rxevq_checker (
    input logic        clk,
    input logic        rst,
    input logic        diag_mode,
    input logic        reg_wr_set,
    input logic [31:0] reg_wdata,
    input logic [31:0] ctrl_rdata,
    input logic        evt_valid,
    input logic [1:0]  evt_kind,
    input logic        evt_ready,
    input logic        nq_pop,
    input logic        nq_is_ts,
    input logic        nq_empty,
    input logic        nq_full,
    input logic        eq_empty,
    input logic        eq_full
);

    a_r1_reset_value: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (ctrl_rdata == 32'h0000_0300 && nq_empty && eq_empty));

    a_r3_flush_empties: assert property (@(posedge clk) disable iff (rst)
        (reg_wr_set && reg_wdata[31] && diag_mode) |=> (nq_empty && eq_empty));

    a_r7_inhibit_blocks: assert property (@(posedge clk) disable iff (rst)
        ctrl_rdata[4] |-> !evt_ready);

    a_r8_full_blocks_good: assert property (@(posedge clk) disable iff (rst)
        (nq_full && evt_kind == 2'd0) |-> !evt_ready);

    a_r9_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(nq_full && nq_empty) && !(eq_full && eq_empty));

    a_r6_ts_leads: assert property (@(posedge clk) disable iff (rst)
        (evt_valid && evt_ready && evt_kind == 2'd0 && ctrl_rdata[3] &&
         nq_empty && !nq_pop) |=> (!nq_empty && nq_is_ts));

endmodule

bind rxevq_top rxevq_checker u_rxevq_checker (
    .clk       (clk),
    .rst       (rst),
    .diag_mode (diag_mode),
    .reg_wr_set(reg_wr_set),
    .reg_wdata (reg_wdata),
    .ctrl_rdata(ctrl_rdata),
    .evt_valid (evt_valid),
    .evt_kind  (evt_kind),
    .evt_ready (evt_ready),
    .nq_pop    (nq_pop),
    .nq_is_ts  (nq_is_ts),
    .nq_empty  (nq_empty),
    .nq_full   (nq_full),
    .eq_empty  (eq_empty),
    .eq_full   (eq_full)
);

// File: tb/tb_rxevq_top.sv
module tb_rxevq_top;

    localparam int CLK_P = 10;
    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        diag_mode = 1'b0, reg_wr_set = 1'b0, reg_wr_clr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] ctrl_rdata;
    logic [15:0] ts_rdata;
    logic        evt_valid = 1'b0;
    logic [1:0]  evt_kind = '0;
    logic [15:0] evt_data = '0;
    logic        evt_ready;
    logic        nq_pop = 1'b0, eq_pop = 1'b0;
    logic        nq_is_ts, nq_empty, nq_full, eq_is_ts, eq_empty, eq_full;
    logic [1:0]  nq_kind, eq_kind;
    logic [15:0] nq_data, eq_data;

    rxevq_top #(.DEPTH(DEPTH)) dut (.*);

    always #(CLK_P/2) clk = ~clk;

    int          n_tests = 0, n_fail = 0;
    bit          done = 0;
    logic [31:0] m_ctrl;
    logic [15:0] m_t, m_ts;
    logic [18:0] mq0[$], mq1[$];

    function automatic int route(logic [1:0] k, logic [31:0] c);
        case (k)
            2'd0: return 1;
            2'd1: return c[2] ? 1 : 0;
            2'd2: return (c[7] || !c[2]) ? 2 : 1;
            default: return c[6] ? 1 : 0;
        endcase
    endfunction

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic idle();
        reg_wr_set = 0; reg_wr_clr = 0; reg_wdata = '0; diag_mode = 0;
        evt_valid = 0; nq_pop = 0; eq_pop = 0;
    endtask

    task automatic cycle(string tag);
        int r, need;
        bit fl, rdy, acc;
        #1;
        fl   = reg_wr_set && reg_wdata[31] && diag_mode;
        r    = route(evt_kind, m_ctrl);
        need = m_ctrl[3] ? 2 : 1;
        rdy  = !fl && !m_ctrl[4] && (r == 0 ||
               (r == 1 && mq0.size() + need <= DEPTH) ||
               (r == 2 && mq1.size() + need <= DEPTH));
        chk(tag, "ctrl", ctrl_rdata, m_ctrl);
        chk(tag, "ready", 32'(evt_ready), 32'(rdy));
        chk(tag, "nq_empty", 32'(nq_empty), 32'(mq0.size() == 0));
        chk(tag, "nq_full", 32'(nq_full), 32'(mq0.size() == DEPTH));
        chk(tag, "eq_empty", 32'(eq_empty), 32'(mq1.size() == 0));
        chk(tag, "eq_full", 32'(eq_full), 32'(mq1.size() == DEPTH));
        if (mq0.size() > 0) chk(tag, "nq_head", 32'({nq_is_ts, nq_kind, nq_data}), 32'(mq0[0]));
        if (mq1.size() > 0) chk(tag, "eq_head", 32'({eq_is_ts, eq_kind, eq_data}), 32'(mq1[0]));
        chk(tag, "ts_reg", 32'(ts_rdata), 32'(m_ts));
        acc = evt_valid && rdy;
        @(posedge clk);
        if (fl) begin
            mq0.delete(); mq1.delete();
        end else begin
            if (nq_pop && mq0.size() > 0) begin void'(mq0.pop_front()); m_ts = m_t; end
            if (eq_pop && mq1.size() > 0) void'(mq1.pop_front());
            if (acc && r == 1) begin
                if (m_ctrl[3]) mq0.push_back({1'b1, evt_kind, m_t});
                mq0.push_back({1'b0, evt_kind, evt_data});
            end
            if (acc && r == 2) begin
                if (m_ctrl[3]) mq1.push_back({1'b1, evt_kind, m_t});
                mq1.push_back({1'b0, evt_kind, evt_data});
            end
        end
        if (reg_wr_set) m_ctrl = m_ctrl | (reg_wdata & 32'h7FF);
        if (reg_wr_clr) m_ctrl = m_ctrl & ~(reg_wdata & 32'h7FF);
        m_t = m_t + 1;
        @(negedge clk);
    endtask

    task automatic wr(bit s, bit c, logic [31:0] d, bit dg, string tag);
        reg_wr_set = s; reg_wr_clr = c; reg_wdata = d; diag_mode = dg;
        cycle(tag); idle();
    endtask

    task automatic ev(logic [1:0] k, logic [15:0] d, string tag);
        evt_valid = 1; evt_kind = k; evt_data = d;
        cycle(tag); idle();
    endtask

    task automatic popq(bit e, int n, string tag);
        for (int i = 0; i < n; i++) begin
            if (e) eq_pop = 1; else nq_pop = 1;
            cycle(tag); idle();
        end
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] t_acc;
        void'($urandom(32'd20240611));
        m_ctrl = 32'h300; m_t = 0; m_ts = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;

        // R1 reset state
        #1;
        chk("R1", "ctrl", ctrl_rdata, 32'h0000_0300);
        chk("R1", "empty", 32'({nq_empty, eq_empty, nq_full, eq_full}), 32'b1100);
        chk("R1", "ts_reg", 32'(ts_rdata), 32'h0);
        cycle("R1");

        // R2 set/clear semantics, reserved bits, clash
        wr(1, 0, 32'hFFFF_FFFF, 0, "R2");
        #1 chk("R2", "set all", ctrl_rdata, 32'h0000_07FF);
        wr(0, 1, 32'hFFFF_FFFF, 0, "R2");
        wr(1, 1, 32'h0000_0008, 0, "R2");
        #1 chk("R2", "clear wins", ctrl_rdata, 32'h0);
        wr(1, 0, 32'h0000_0300, 0, "R2");

        // R4 good / bad / overflow routing
        ev(2'd0, 16'h1111, "R4");
        ev(2'd1, 16'h2222, "R4");
        ev(2'd3, 16'h3333, "R4");
        wr(1, 0, 32'h44, 0, "R4");
        ev(2'd1, 16'h4444, "R4");
        ev(2'd3, 16'h5555, "R4");
        popq(0, 4, "R4");
        wr(0, 1, 32'h44, 0, "R4");

        // R5 error routing
        ev(2'd2, 16'hE001, "R5");
        wr(1, 0, 32'h4, 0, "R5");
        ev(2'd2, 16'hE002, "R5");
        wr(1, 0, 32'h80, 0, "R5");
        ev(2'd2, 16'hE003, "R5");
        #1 chk("R5", "eq_empty", 32'(eq_empty), 32'h0);
        popq(1, 3, "R5");
        popq(0, 2, "R5");
        wr(0, 1, 32'h84, 0, "R5");

        // R6 timestamp pairs
        wr(1, 0, 32'h8, 0, "R6");
        t_acc = m_t;
        ev(2'd0, 16'hABCD, "R6");
        #1 chk("R6", "ts entry", 32'({nq_is_ts, nq_data}), 32'({1'b1, t_acc}));

        // R8 / R9 fill normal queue with pairs
        for (int i = 0; i < 7; i++) ev(2'd0, 16'(i), "R9");
        #1 chk("R9", "full", 32'(nq_full), 32'h1);
        ev(2'd0, 16'hDEAD, "R8");
        ev(2'd2, 16'hE0E0, "R8");
        ev(2'd1, 16'hBADD, "R8");
        popq(0, 1, "R8");
        ev(2'd0, 16'hBEEF, "R8");
        wr(0, 1, 32'h8, 0, "R8");
        ev(2'd0, 16'hCAFE, "R8");
        #1 chk("R8", "full again", 32'(nq_full), 32'h1);

        // R3 flush
        wr(1, 0, 32'h8000_0000, 0, "R3");
        #1 chk("R3", "no diag keeps", 32'(nq_empty), 32'h0);
        wr(1, 0, 32'h8000_0000, 1, "R3");
        #1 chk("R3", "flushed", 32'({nq_empty, eq_empty, ctrl_rdata[31]}), 32'b110);

        // R7 inhibit
        wr(1, 0, 32'h10, 0, "R7");
        ev(2'd0, 16'h7777, "R7");
        ev(2'd2, 16'h7778, "R7");
        wr(0, 1, 32'h10, 0, "R7");

        // R10 timestamp register on pop
        ev(2'd0, 16'h0A0A, "R10");
        cycle("R10");
        t_acc = m_t;
        popq(0, 1, "R10");
        #1 chk("R10", "ts capture", 32'(ts_rdata), 32'(t_acc));
        popq(0, 1, "R10");

        // random traffic
        for (int c = 0; c < 5000; c++) begin
            int rnd;
            rnd = int'($urandom % 100);
            evt_valid = $urandom % 2;
            evt_kind  = 2'($urandom);
            evt_data  = 16'($urandom);
            nq_pop    = ($urandom % 5) < 2;
            eq_pop    = ($urandom % 3) == 0;
            if (rnd < 4) begin
                reg_wr_set = 1; reg_wdata = 32'($urandom) & 32'hCC;
            end else if (rnd < 9) begin
                reg_wr_clr = 1; reg_wdata = (32'($urandom) & 32'hCC) | 32'h10;
            end else if (rnd == 9) begin
                reg_wr_set = 1; reg_wdata = 32'h10;
            end else if (rnd == 10 && ($urandom % 4) == 0) begin
                reg_wr_set = 1; reg_wdata = 32'h8000_0000; diag_mode = 1;
            end
            cycle("R5");
            idle();
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule